// File: doc/BRIEF.md
# Platform System Register File

This block is a bank of 32-bit platform control and status registers on a plain register bus. The bus carries a word address, a write strobe with write data and a read strobe. Read data comes back from a register one clock after the read strobe. The bank holds a fixed board identity word and two processor identity words. It holds a user LED register that drives eight output pins and a flash write-protect control bit. It also has two flag words that are set and cleared at separate addresses. One flag word is cleared by every reset. The other keeps its value across system reset and is cleared only by the power-on reset.

Several registers only mirror pins: the board switches, the configuration switches, the card-detect and card write-protect status, and the master daughterboard site. Two read-only counters advance on tick-enable inputs, one at 100 Hz and one at 24 MHz. The three configuration-bus transaction words are decoded here and flagged to a neighbouring block, which supplies their read data. Software finds every field at the word address listed in the requirements. Word address N corresponds to byte offset 4·N.

Top module: `sysreg_bank`

## Requirements
- R1: While either reset is low and after its release, rdata is 0, led_out is 0, flash_wp_n is 0, and both flag words and both counters read 0.
- R2: Word 0 (byte offset 0x000) reads {4'h1, BOARD_HBI in bits 27:16, 16'h0100}. Word 33 (offset 0x084) reads {20'h0C000, DB1_HBI in bits 11:0}. Word 34 (offset 0x088) reads {20'h14000, DB2_HBI in bits 11:0}. Writes to these three words are ignored.
- R3: A write to word 2 (offset 0x008) stores wdata[7:0] and drives led_out. Reads return the last value written in bits 7:0 and 0 in the upper bits. led_out changes only on such a write.
- R4: A write to word 12 (offset 0x030) ORs wdata into the volatile flags. A write to word 13 (offset 0x034) clears every flag bit where wdata is 1. Word 12 reads the flags. Word 13 reads 0.
- R5: The persistent flags behave the same way: set and read at word 14 (offset 0x038), clear at word 15 (offset 0x03C), and word 15 reads 0.
- R6: rst_n clears the volatile flags but leaves the persistent flags unchanged. por_n clears both.
- R7: Word 18 (offset 0x048) reads card_in in bit 0 and card_wp in bit 1, with all other bits 0. Writes to it are ignored.
- R8: Word 19 (offset 0x04C) bit 0 is read/write and drives flash_wp_n. Upper bits read 0.
- R9: Word 24 (offset 0x060) reads master_db2 in bit 14 and 0 elsewhere.
- R10: Word 9 (offset 0x024) and word 23 (offset 0x05C) count the cycles on which tick_slow and tick_fast, respectively, are high. They wrap modulo 2^CNT_W and ignore writes.
- R11: Word 1 (offset 0x004) reads sw_in. Word 22 (offset 0x058) reads cfg_sw_in.
- R12: cfg_sel is high in the same cycle as a read or write to words 40, 41 or 42 (offsets 0x0A0 to 0x0A8). Reads of those words return cfg_rdata as sampled at the read edge.
- R13: Read data is registered. rdata is 0 in any cycle that follows a cycle without rd_en. Unmapped words read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| sw_in | input | 32 | Board switch levels |
| cfg_sw_in | input | 32 | Configuration switch levels |
| card_in | input | 1 | Card inserted |
| card_wp | input | 1 | Card write-protected |
| master_db2 | input | 1 | Master site is second daughterboard |
| tick_slow | input | 1 | 100 Hz tick enable |
| tick_fast | input | 1 | 24 MHz tick enable |
| cfg_rdata | input | 32 | Read data from configuration-bus block |
| cfg_sel | output | 1 | Access targets configuration-bus words |
| led_out | output | LED_W | User LED drive |
| flash_wp_n | output | 1 | Flash write-protect, active low |

## Verification
On every cycle, the assertions hold the LED and flash outputs steady unless their own word is written. They also check that rdata stays zero after idle cycles, that the counters hold or step by one according to their tick, and that the persistent flags survive everything except an addressed write or power-on reset. The identity field position and the pass-through of configuration read data are checked at each read. The OR and clear arithmetic of the flag words, readback of every field, the different effects of the two resets and counter wrap at the narrow width can only be shown by the bench's scenarios against its model.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

   localparam int DATA_W = 32;

   // word indices (byte offset >> 2)
   localparam int unsigned WIX_IDENT   = 0;
   localparam int unsigned WIX_SW      = 1;
   localparam int unsigned WIX_LED     = 2;
   localparam int unsigned WIX_SLOW    = 9;
   localparam int unsigned WIX_FLGSET  = 12;
   localparam int unsigned WIX_FLGCLR  = 13;
   localparam int unsigned WIX_NVSET   = 14;
   localparam int unsigned WIX_NVCLR   = 15;
   localparam int unsigned WIX_CARD    = 18;
   localparam int unsigned WIX_FLASH   = 19;
   localparam int unsigned WIX_CFGSW   = 22;
   localparam int unsigned WIX_FAST    = 23;
   localparam int unsigned WIX_MISC    = 24;
   localparam int unsigned WIX_PROC0   = 33;
   localparam int unsigned WIX_PROC1   = 34;
   localparam int unsigned WIX_CFG_LO  = 40;
   localparam int unsigned WIX_CFG_HI  = 42;

   localparam int MISC_MASTER_BIT = 14;
   localparam int MIN_ADDR_W      = 6;

   typedef enum logic {FLAG_VOLATILE = 1'b0, FLAG_PERSIST = 1'b1} flag_kind_e;

endpackage

// File: rtl/sysreg_flag_word.sv
module sysreg_flag_word
   import sysreg_pkg::*;
#(
   parameter int         W    = 32,
   parameter flag_kind_e KIND = FLAG_VOLATILE
) (
   input  logic         clk,
   input  logic         sys_rst_n,
   input  logic         por_n,
   input  logic         set_en,
   input  logic         clr_en,
   input  logic [W-1:0] bits,
   output logic [W-1:0] flags
);

   logic          arst_n;
   logic [W-1:0]  set_mask;
   logic [W-1:0]  clr_mask;

   generate
      if (KIND == FLAG_PERSIST) begin : g_persist
         assign arst_n = por_n;
         logic unused_sys;
         assign unused_sys = sys_rst_n;
      end else begin : g_volatile
         assign arst_n = sys_rst_n & por_n;
      end
   endgenerate

   assign set_mask = set_en ? bits : '0;
   assign clr_mask = clr_en ? bits : '0;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) flags <= '0;
      else         flags <= (flags | set_mask) & ~clr_mask;
   end

endmodule

// File: rtl/sysreg_tick_counter.sv
module sysreg_tick_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic         tick,
   output logic [W-1:0] count
);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)   count <= '0;
      else if (tick) count <= count + 1'b1;
   end

endmodule

// File: rtl/sysreg_rw_field.sv
module sysreg_rw_field #(
   parameter int           W   = 8,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) q <= RST;
      else if (we) q <= d;
   end

endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
   import sysreg_pkg::*;
#(
   parameter int          ADDR_W     = 8,
   parameter int          LED_W      = 8,
   parameter int          CNT_W      = 32,
   parameter logic [3:0]  ID_REV     = 4'h1,
   parameter logic [11:0] BOARD_HBI  = 12'h190,
   parameter logic [15:0] ID_LOW     = 16'h0100,
   parameter logic [11:0] DB1_HBI    = 12'h237,
   parameter logic [11:0] DB2_HBI    = 12'h249,
   parameter logic [19:0] PROC0_HI   = 20'h0C000,
   parameter logic [19:0] PROC1_HI   = 20'h14000,
   parameter logic        FLASH_RST  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic [31:0]       sw_in,
   input  logic [31:0]       cfg_sw_in,
   input  logic              card_in,
   input  logic              card_wp,
   input  logic              master_db2,
   input  logic              tick_slow,
   input  logic              tick_fast,
   input  logic [31:0]       cfg_rdata,
   output logic              cfg_sel,
   output logic [LED_W-1:0]  led_out,
   output logic              flash_wp_n
);

   localparam logic [ADDR_W-1:0] A_IDENT  = ADDR_W'(WIX_IDENT);
   localparam logic [ADDR_W-1:0] A_SW     = ADDR_W'(WIX_SW);
   localparam logic [ADDR_W-1:0] A_LED    = ADDR_W'(WIX_LED);
   localparam logic [ADDR_W-1:0] A_SLOW   = ADDR_W'(WIX_SLOW);
   localparam logic [ADDR_W-1:0] A_FLGSET = ADDR_W'(WIX_FLGSET);
   localparam logic [ADDR_W-1:0] A_FLGCLR = ADDR_W'(WIX_FLGCLR);
   localparam logic [ADDR_W-1:0] A_NVSET  = ADDR_W'(WIX_NVSET);
   localparam logic [ADDR_W-1:0] A_NVCLR  = ADDR_W'(WIX_NVCLR);
   localparam logic [ADDR_W-1:0] A_CARD   = ADDR_W'(WIX_CARD);
   localparam logic [ADDR_W-1:0] A_FLASH  = ADDR_W'(WIX_FLASH);
   localparam logic [ADDR_W-1:0] A_CFGSW  = ADDR_W'(WIX_CFGSW);
   localparam logic [ADDR_W-1:0] A_FAST   = ADDR_W'(WIX_FAST);
   localparam logic [ADDR_W-1:0] A_MISC   = ADDR_W'(WIX_MISC);
   localparam logic [ADDR_W-1:0] A_PROC0  = ADDR_W'(WIX_PROC0);
   localparam logic [ADDR_W-1:0] A_PROC1  = ADDR_W'(WIX_PROC1);
   localparam logic [ADDR_W-1:0] A_CFGLO  = ADDR_W'(WIX_CFG_LO);
   localparam logic [ADDR_W-1:0] A_CFGHI  = ADDR_W'(WIX_CFG_HI);

   localparam logic [31:0] IDENT_WORD = {ID_REV, BOARD_HBI, ID_LOW};
   localparam logic [31:0] PROC0_WORD = {PROC0_HI, DB1_HBI};
   localparam logic [31:0] PROC1_WORD = {PROC1_HI, DB2_HBI};

   // elaboration-time parameter checks
   generate
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
         $error("sysreg_bank: ADDR_W too small for the register map");
      end
      if (LED_W < 1 || LED_W > DATA_W) begin : g_bad_led
         $error("sysreg_bank: LED_W out of range");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("sysreg_bank: CNT_W out of range");
      end
   endgenerate

   logic sys_arst_n;
   assign sys_arst_n = rst_n & por_n;

   // write decode
   logic we_led, we_flash, we_fset, we_fclr, we_nset, we_nclr;
   assign we_led   = wr_en && (addr == A_LED);
   assign we_flash = wr_en && (addr == A_FLASH);
   assign we_fset  = wr_en && (addr == A_FLGSET);
   assign we_fclr  = wr_en && (addr == A_FLGCLR);
   assign we_nset  = wr_en && (addr == A_NVSET);
   assign we_nclr  = wr_en && (addr == A_NVCLR);

   assign cfg_sel = (rd_en || wr_en) && (addr >= A_CFGLO) && (addr <= A_CFGHI);

   // storage
   logic [LED_W-1:0] led_q;
   logic [0:0]       flash_q;
   logic [31:0]      vol_flags;
   logic [31:0]      nv_flags;
   logic [CNT_W-1:0] cnt_slow;
   logic [CNT_W-1:0] cnt_fast;

   sysreg_rw_field #(.W(LED_W), .RST('0)) i_led (
      .clk(clk), .arst_n(sys_arst_n), .we(we_led),
      .d(wdata[LED_W-1:0]), .q(led_q)
   );

   sysreg_rw_field #(.W(1), .RST(FLASH_RST)) i_flash (
      .clk(clk), .arst_n(sys_arst_n), .we(we_flash),
      .d(wdata[0:0]), .q(flash_q)
   );

   logic [1:0][31:0] flag_words;
   logic [1:0]       flag_set, flag_clr;
   assign flag_set = {we_nset, we_fset};
   assign flag_clr = {we_nclr, we_fclr};

   generate
      for (genvar k = 0; k < 2; k++) begin : g_flags
         localparam flag_kind_e KIND_K = (k == 0) ? FLAG_VOLATILE : FLAG_PERSIST;
         sysreg_flag_word #(.W(32), .KIND(KIND_K)) i_word (
            .clk(clk), .sys_rst_n(rst_n), .por_n(por_n),
            .set_en(flag_set[k]), .clr_en(flag_clr[k]),
            .bits(wdata), .flags(flag_words[k])
         );
      end
   endgenerate

   assign vol_flags = flag_words[0];
   assign nv_flags  = flag_words[1];

   logic [1:0]            ticks;
   logic [1:0][CNT_W-1:0] counts;
   assign ticks = {tick_fast, tick_slow};

   generate
      for (genvar c = 0; c < 2; c++) begin : g_cnt
         sysreg_tick_counter #(.W(CNT_W)) i_cnt (
            .clk(clk), .arst_n(sys_arst_n), .tick(ticks[c]), .count(counts[c])
         );
      end
   endgenerate

   assign cnt_slow = counts[0];
   assign cnt_fast = counts[1];

   // read mux
   logic [31:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if ((addr >= A_CFGLO) && (addr <= A_CFGHI)) begin
         rd_mux = cfg_rdata;
      end else begin
         case (addr)
            A_IDENT:  rd_mux = IDENT_WORD;
            A_SW:     rd_mux = sw_in;
            A_LED:    rd_mux = 32'(led_q);
            A_SLOW:   rd_mux = 32'(cnt_slow);
            A_FLGSET: rd_mux = vol_flags;
            A_NVSET:  rd_mux = nv_flags;
            A_CARD:   rd_mux = {30'b0, card_wp, card_in};
            A_FLASH:  rd_mux = {31'b0, flash_q};
            A_CFGSW:  rd_mux = cfg_sw_in;
            A_FAST:   rd_mux = 32'(cnt_fast);
            A_MISC:   rd_mux = 32'(master_db2) << MISC_MASTER_BIT;
            A_PROC0:  rd_mux = PROC0_WORD;
            A_PROC1:  rd_mux = PROC1_WORD;
            default:  rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge sys_arst_n) begin
      if (!sys_arst_n) rdata <= '0;
      else             rdata <= rd_en ? rd_mux : '0;
   end

   assign led_out    = led_q;
   assign flash_wp_n = flash_q[0];

endmodule

// File: rtl/sysreg_bank_chk.sv
module sysreg_bank_chk
   import sysreg_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int          LED_W     = 8,
   parameter int          CNT_W     = 32,
   parameter logic [11:0] BOARD_HBI = 12'h190
) (
   input logic              clk,
   input logic              rst_n,
   input logic              por_n,
   input logic              rd_en,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       cfg_rdata,
   input logic [31:0]       rdata,
   input logic [LED_W-1:0]  led_out,
   input logic              flash_wp_n,
   input logic              tick_slow,
   input logic              tick_fast,
   input logic [CNT_W-1:0]  cnt_slow,
   input logic [CNT_W-1:0]  cnt_fast,
   input logic [31:0]       nv_flags
);

   logic any_rst;
   assign any_rst = !(rst_n && por_n);

   // R3
   led_hold_chk: assert property (@(posedge clk) disable iff (any_rst)
      !(wr_en && addr == ADDR_W'(WIX_LED)) |=> $stable(led_out));

   // R8
   flash_hold_chk: assert property (@(posedge clk) disable iff (any_rst)
      !(wr_en && addr == ADDR_W'(WIX_FLASH)) |=> $stable(flash_wp_n));

   // R13
   idle_rdata_chk: assert property (@(posedge clk) disable iff (any_rst)
      !rd_en |=> rdata == '0);

   // R12
   cfg_pass_chk: assert property (@(posedge clk) disable iff (any_rst)
      (rd_en && addr >= ADDR_W'(WIX_CFG_LO) && addr <= ADDR_W'(WIX_CFG_HI))
      |=> rdata == $past(cfg_rdata));

   // R2
   ident_field_chk: assert property (@(posedge clk) disable iff (any_rst)
      (rd_en && addr == ADDR_W'(WIX_IDENT)) |=> rdata[27:16] == BOARD_HBI);

   // R10
   slow_hold_chk: assert property (@(posedge clk) disable iff (any_rst)
      !tick_slow |=> $stable(cnt_slow));

   // R10
   fast_step_chk: assert property (@(posedge clk) disable iff (any_rst)
      tick_fast |=> cnt_fast == $past(cnt_fast) + 1'b1);

   // R6
   nv_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
      !(wr_en && (addr == ADDR_W'(WIX_NVSET) || addr == ADDR_W'(WIX_NVCLR)))
      |=> $stable(nv_flags));

endmodule

bind sysreg_bank sysreg_bank_chk #(
   .ADDR_W(ADDR_W), .LED_W(LED_W), .CNT_W(CNT_W), .BOARD_HBI(BOARD_HBI)
) i_chk (
   .clk(clk), .rst_n(rst_n), .por_n(por_n), .rd_en(rd_en), .wr_en(wr_en),
   .addr(addr), .cfg_rdata(cfg_rdata), .rdata(rdata), .led_out(led_out),
   .flash_wp_n(flash_wp_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
   .cnt_slow(cnt_slow), .cnt_fast(cnt_fast), .nv_flags(nv_flags)
);

// File: tb/test_sysreg_bank.sv
`timescale 1ns/1ps
module test_sysreg_bank;

   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n, por_n, rd_en, wr_en;
   logic [AW-1:0] addr;
   logic [31:0]   wdata, sw_in, cfg_sw_in, cfg_rdata;
   logic          card_in, card_wp, master_db2, tick_slow, tick_fast;
   logic [31:0]   rdata, rdata_n;
   logic          cfg_sel, cfg_sel_n, flash_wp_n, flash_wp_n_n;
   logic [7:0]    led_out, led_out_n;

   int checks = 0;
   int errors = 0;

   // bench model
   logic [7:0]  m_led;
   logic        m_flash;
   logic [31:0] m_fl, m_nv, m_cs, m_cf;

   always #2.5 clk = ~clk;

   sysreg_bank i_sysreg_bank (
      .clk(clk), .rst_n(rst_n), .por_n(por_n), .rd_en(rd_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .sw_in(sw_in),
      .cfg_sw_in(cfg_sw_in), .card_in(card_in), .card_wp(card_wp),
      .master_db2(master_db2), .tick_slow(tick_slow), .tick_fast(tick_fast),
      .cfg_rdata(cfg_rdata), .cfg_sel(cfg_sel), .led_out(led_out),
      .flash_wp_n(flash_wp_n)
   );

   sysreg_bank #(.CNT_W(4)) i_sysreg_bank_narrow (
      .clk(clk), .rst_n(rst_n), .por_n(por_n), .rd_en(rd_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata_n), .sw_in(sw_in),
      .cfg_sw_in(cfg_sw_in), .card_in(card_in), .card_wp(card_wp),
      .master_db2(master_db2), .tick_slow(tick_slow), .tick_fast(tick_fast),
      .cfg_rdata(cfg_rdata), .cfg_sel(cfg_sel_n), .led_out(led_out_n),
      .flash_wp_n(flash_wp_n_n)
   );

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%08h exp=%08h", req, got, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(int a);
      case (a)
         0:          return 32'h1190_0100;
         1:          return sw_in;
         2:          return {24'b0, m_led};
         9:          return m_cs;
         12:         return m_fl;
         14:         return m_nv;
         18:         return {30'b0, card_wp, card_in};
         19:         return {31'b0, m_flash};
         22:         return cfg_sw_in;
         23:         return m_cf;
         24:         return {17'b0, master_db2, 14'b0};
         33:         return 32'h0C00_0237;
         34:         return 32'h1400_0249;
         40, 41, 42: return cfg_rdata;
         default:    return 32'h0;
      endcase
   endfunction

   function automatic string req_of(int a);
      case (a)
         0, 33, 34: return "R2";
         2:         return "R3";
         12, 13:    return "R4";
         14, 15:    return "R5";
         18:        return "R7";
         19:        return "R8";
         24:        return "R9";
         9, 23:     return "R10";
         1, 22:     return "R11";
         40, 41, 42: return "R12";
         default:   return "R13";
      endcase
   endfunction

   function automatic int pick_addr(int i);
      case (i)
         0: return 0;   1: return 1;   2: return 2;   3: return 9;
         4: return 12;  5: return 13;  6: return 14;  7: return 15;
         8: return 18;  9: return 19;  10: return 22; 11: return 23;
         12: return 24; 13: return 33; 14: return 34; 15: return 40;
         16: return 42; 17: return 5;  18: return 63; default: return 200;
      endcase
   endfunction

   function automatic void model_wr(int a, logic [31:0] d);
      case (a)
         2:  m_led = d[7:0];
         12: m_fl = m_fl | d;
         13: m_fl = m_fl & ~d;
         14: m_nv = m_nv | d;
         15: m_nv = m_nv & ~d;
         19: m_flash = d[0];
         default: ;
      endcase
   endfunction

   task automatic do_write(int a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
      model_wr(a, d);
   endtask

   task automatic do_read(int a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = AW'(a);
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic rd_check(int a, string req);
      logic [31:0] e, got;
      e = exp_rd(a);
      do_read(a, got);
      check(req, got, e);
   endtask

   task automatic pulse_ticks(int ns, int nf);
      for (int i = 0; i < ((ns > nf) ? ns : nf); i++) begin
         @(negedge clk);
         tick_slow = (i < ns); tick_fast = (i < nf);
      end
      @(negedge clk);
      tick_slow = 1'b0; tick_fast = 1'b0;
      m_cs = m_cs + 32'(ns); m_cf = m_cf + 32'(nf);
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] got;
      void'($urandom(32'h5EED_0042));
      rst_n = 0; por_n = 0; rd_en = 0; wr_en = 0; addr = '0; wdata = '0;
      sw_in = 32'hA5A5_0F0F; cfg_sw_in = 32'h0000_1234; cfg_rdata = 32'hCAFE_0001;
      card_in = 1; card_wp = 0; master_db2 = 1; tick_slow = 0; tick_fast = 0;
      m_led = 0; m_flash = 0; m_fl = 0; m_nv = 0; m_cs = 0; m_cf = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 rdata", rdata, 32'h0);
      check("R1 led", 32'(led_out), 32'h0);
      check("R1 flash", 32'(flash_wp_n), 32'h0);
      rst_n = 1; por_n = 1;
      rd_check(12, "R1 flags");
      rd_check(14, "R1 nvflags");
      rd_check(9, "R1 slow cnt");

      // R2 identity and ignored writes
      do_write(0, 32'hFFFF_FFFF);
      rd_check(0, "R2 ident");
      do_write(33, 32'h0);
      rd_check(33, "R2 proc0");
      rd_check(34, "R2 proc1");

      // R3 LED readback
      do_write(2, 32'hFFFF_FF5A);
      check("R3 led_out", 32'(led_out), 32'h5A);
      rd_check(2, "R3 led read");

      // R4 / R5 set and clear
      do_write(12, 32'h0000_00F0);
      do_write(12, 32'h0000_0F00);
      do_write(13, 32'h0000_0130);
      rd_check(12, "R4 flags");
      rd_check(13, "R4 clr reads zero");
      do_write(14, 32'h8000_0001);
      do_write(15, 32'h0000_0001);
      rd_check(14, "R5 nvflags");
      rd_check(15, "R5 nvclr reads zero");

      // R7 card status read-only
      card_in = 0; card_wp = 1;
      do_write(18, 32'hFFFF_FFFF);
      rd_check(18, "R7 card");

      // R8 flash
      do_write(19, 32'hFFFF_FFFF);
      check("R8 flash pin", 32'(flash_wp_n), 32'h1);
      rd_check(19, "R8 flash read");

      // R9 misc
      rd_check(24, "R9 master=1");
      master_db2 = 0;
      rd_check(24, "R9 master=0");

      // R11 switches
      rd_check(1, "R11 sw");
      rd_check(22, "R11 cfgsw");

      // R12 config window
      @(negedge clk);
      rd_en = 1; addr = AW'(41);
      #1 check("R12 cfg_sel rd", 32'(cfg_sel), 32'h1);
      @(negedge clk);
      rd_en = 0;
      check("R12 cfg rdata", rdata, cfg_rdata);
      #1 check("R12 cfg_sel idle", 32'(cfg_sel), 32'h0);

      // R13 unmapped
      do_write(5, 32'hDEAD_BEEF);
      rd_check(5, "R13 unmapped");
      rd_check(2, "R13 led untouched");

      // R10 counters, wrap at narrow width
      do_write(9, 32'h1234_5678);
      pulse_ticks(18, 37);
      rd_check(9, "R10 slow");
      rd_check(23, "R10 fast");
      do_read(23, got);
      check("R10 narrow wrap", rdata_n, 32'd5);

      // R6 reset domains
      do_write(12, 32'h0000_0077);
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1;
      m_fl = 0; m_led = 0; m_flash = 0; m_cs = 0; m_cf = 0;
      rd_check(12, "R6 vol cleared");
      rd_check(14, "R6 nv kept");
      @(negedge clk); por_n = 0;
      @(negedge clk); por_n = 1;
      m_nv = 0;
      rd_check(14, "R6 nv cleared by por");

      // random mixed traffic
      for (int n = 0; n < 400; n++) begin
         int a;
         logic [31:0] d;
         a = pick_addr($urandom_range(0, 19));
         d = $urandom();
         if ($urandom_range(0, 3) == 0) begin
            sw_in = $urandom(); cfg_rdata = $urandom();
            card_in = 1'($urandom()); card_wp = 1'($urandom());
            master_db2 = 1'($urandom());
         end
         if ($urandom_range(0, 1) == 0) do_write(a, d);
         else                           rd_check(a, req_of(a));
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule